// File: doc/BRIEF.md
# PCIe Transmit Credit Gate

This block decides whether a transaction-layer packet may leave the transmitter, based on flow-control credits. Three credit classes are kept apart: posted, non-posted and completion. Each class has a header pool and a data pool. For each pool the link partner advertises a cumulative credit limit. The block keeps its own wrapping count of the credits the local transmitter has used. The credits available are the limit minus that count, taken modulo the field width, the same way FIFO read and write pointers are compared.

A requester presents one packet at a time: its class, its payload length in bytes and, for a read, the number of completion bytes it will bring back. `grant_o` answers in the same cycle. The consumed counters of the chosen class advance on the clock edge that ends a granted cycle. A request that cannot be granted waits with grant low until the partner raises the limit. Each pool has a flag that marks it as infinite, which skips the check for that pool. Non-posted reads are also held back while the completion bytes they would add do not fit in a local receive window. That window is sized by a parameter and drained by a completion-return input.

Top module: `txfc_credit_gate`

## Requirements
- R1: Every granted packet uses exactly one header credit of its own class. With the limit held, that class's available header count drops by one after the grant edge.
- R2: The data cost of a request is ceil(payload_bytes / 16), so 128 bytes costs 8, 17 bytes costs 2 and a request with no payload costs 0. The cost is subtracted from the class's available data count after the grant edge.
- R3: The available count of a pool is limit minus consumed, modulo 256 for header pools and modulo 4096 for data pools. It stays correct when either value wraps. Consumed counters are zero after reset, so the available count then equals the limit.
- R4: A request is granted only when the class has at least 1 available header credit and at least its data cost in available data credits. Otherwise grant stays low and nothing is consumed, and the request is granted in the first cycle in which a raised limit makes it fit. A request whose cost exactly equals the credits available is granted.
- R5: The class code is 0 for posted, 1 for non-posted and 2 for completion. Code 3 is never granted. A grant changes only the pools of its own class.
- R6: When a pool's infinite flag (bit index = class code) is high, that pool's check is skipped. Consumed counts still advance on a grant.
- R7: A non-posted request is granted only if the outstanding completion bytes plus its read bytes do not exceed RXBUF_BYTES (default 1024). Outstanding bytes rise by the read bytes on a non-posted grant. They fall by cpl_ret_bytes_i in each cycle in which cpl_ret_valid_i is high, and never go below zero.
- R8: grant_o is low whenever req_valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lim_hdr_i | input | 3x8 | Advertised cumulative header limit per class |
| lim_data_i | input | 3x12 | Advertised cumulative data limit per class |
| inf_hdr_i | input | 3 | Header pool treated as infinite, per class |
| inf_data_i | input | 3 | Data pool treated as infinite, per class |
| req_valid_i | input | 1 | A packet is offered |
| req_cls_i | input | 2 | Class of the offered packet |
| req_len_i | input | 13 | Payload length in bytes |
| req_rd_bytes_i | input | 11 | Completion bytes a non-posted read will return |
| cpl_ret_valid_i | input | 1 | Completion bytes drained from the receive side |
| cpl_ret_bytes_i | input | 11 | Number of bytes drained |
| grant_o | output | 1 | Offered packet may be sent this cycle |
| avail_hdr_o | output | 3x8 | Available header credits per class |
| avail_data_o | output | 3x12 | Available data credits per class |

## Verification
Payload lengths of 0, 1, 16, 17 and 128 bytes separate a rounding-up cost from a truncating one, and show whether an empty payload is charged. Limits set to one credit below and exactly at the cost separate a `>=` comparison from `>`. Limits raised while a request is held show that the grant follows the limit. A long run of 4096-byte completions drives both counters through several wraps, which shows whether the available count is computed modulo the field width. Read sizes that exactly fill the receive window, or go one byte over it, together with a return larger than the outstanding count, test the window bound and its floor at zero.

// File: rtl/txfc_pkg.sv
package txfc_pkg;
    localparam int NCLS = 3;

    typedef enum logic [1:0] {
        CLS_POSTED = 2'd0,
        CLS_NONPOST = 2'd1,
        CLS_CPL = 2'd2,
        CLS_NONE = 2'd3
    } tlp_cls_e;
endpackage

// File: rtl/txfc_cost.sv
module txfc_cost #(
    parameter int LEN_W    = 13,
    parameter int DATA_W   = 12,
    parameter int UNIT_LG2 = 4
) (
    input  logic [LEN_W-1:0]  len_i,
    output logic [DATA_W-1:0] cost_o
);
    localparam int SUM_W = LEN_W + 1;
    localparam int ROUND = (1 << UNIT_LG2) - 1;

    logic [SUM_W-1:0] rounded;

    always_comb begin
        rounded = {1'b0, len_i} + SUM_W'(ROUND);
        cost_o  = DATA_W'(rounded >> UNIT_LG2);
    end
endmodule

// File: rtl/txfc_pool.sv
module txfc_pool #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] limit_i,
    input  logic         inf_i,
    input  logic [W-1:0] need_i,
    input  logic         take_i,
    output logic [W-1:0] avail_o,
    output logic         ok_o
);
    typedef struct packed {
        logic [W-1:0] used;
    } pool_st_t;

    pool_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d.used = st_q.used + need_i;
        end
        avail_o = limit_i - st_q.used;
        ok_o    = inf_i || (avail_o >= need_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/txfc_rdwin.sv
module txfc_rdwin #(
    parameter int RB_W        = 11,
    parameter int RXBUF_BYTES = 1024
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RB_W-1:0] probe_i,
    input  logic            add_i,
    input  logic            ret_i,
    input  logic [RB_W-1:0] ret_bytes_i,
    output logic            fit_o,
    output logic [RB_W-1:0] out_o
);
    localparam int SW = RB_W + 1;

    typedef struct packed {
        logic [RB_W-1:0] out;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [SW-1:0] sum;

    always_comb begin
        st_d  = st_q;
        fit_o = ({1'b0, st_q.out} + {1'b0, probe_i}) <= SW'(RXBUF_BYTES);
        sum   = {1'b0, st_q.out} + (add_i ? {1'b0, probe_i} : '0);
        if (ret_i) begin
            sum = (sum > {1'b0, ret_bytes_i}) ? (sum - {1'b0, ret_bytes_i}) : '0;
        end
        st_d.out = RB_W'(sum);
        out_o    = st_q.out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/txfc_credit_gate.sv
module txfc_credit_gate
    import txfc_pkg::*;
#(
    parameter int HDR_W       = 8,
    parameter int DATA_W      = 12,
    parameter int LEN_W       = 13,
    parameter int UNIT_LG2    = 4,
    parameter int RXBUF_BYTES = 1024,
    localparam int RB_W       = $clog2(RXBUF_BYTES + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCLS-1:0][HDR_W-1:0]   lim_hdr_i,
    input  logic [NCLS-1:0][DATA_W-1:0]  lim_data_i,
    input  logic [NCLS-1:0]              inf_hdr_i,
    input  logic [NCLS-1:0]              inf_data_i,
    input  logic                         req_valid_i,
    input  logic [1:0]                   req_cls_i,
    input  logic [LEN_W-1:0]             req_len_i,
    input  logic [RB_W-1:0]              req_rd_bytes_i,
    input  logic                         cpl_ret_valid_i,
    input  logic [RB_W-1:0]              cpl_ret_bytes_i,
    output logic                         grant_o,
    output logic [NCLS-1:0][HDR_W-1:0]   avail_hdr_o,
    output logic [NCLS-1:0][DATA_W-1:0]  avail_data_o
);
    logic [DATA_W-1:0] cost;
    logic [NCLS-1:0]   hdr_ok, dat_ok, take;
    logic              sel_ok, np_fit, np_ok;
    logic [RB_W-1:0]   np_out_bytes;

    txfc_cost #(.LEN_W(LEN_W), .DATA_W(DATA_W), .UNIT_LG2(UNIT_LG2)) cost_i (
        .len_i (req_len_i),
        .cost_o(cost)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        txfc_pool #(.W(HDR_W)) hdr_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .limit_i(lim_hdr_i[c]),
            .inf_i  (inf_hdr_i[c]),
            .need_i (HDR_W'(1)),
            .take_i (take[c]),
            .avail_o(avail_hdr_o[c]),
            .ok_o   (hdr_ok[c])
        );
        txfc_pool #(.W(DATA_W)) dat_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .limit_i(lim_data_i[c]),
            .inf_i  (inf_data_i[c]),
            .need_i (cost),
            .take_i (take[c]),
            .avail_o(avail_data_o[c]),
            .ok_o   (dat_ok[c])
        );
    end

    txfc_rdwin #(.RB_W(RB_W), .RXBUF_BYTES(RXBUF_BYTES)) rdwin_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_i    (req_rd_bytes_i),
        .add_i      (take[CLS_NONPOST]),
        .ret_i      (cpl_ret_valid_i),
        .ret_bytes_i(cpl_ret_bytes_i),
        .fit_o      (np_fit),
        .out_o      (np_out_bytes)
    );

    always_comb begin
        sel_ok = 1'b0;
        for (int c = 0; c < NCLS; c++) begin
            if (req_cls_i == 2'(c)) begin
                sel_ok = hdr_ok[c] && dat_ok[c];
            end
        end
        np_ok   = (req_cls_i != CLS_NONPOST) || np_fit;
        grant_o = req_valid_i && sel_ok && np_ok;
        for (int c = 0; c < NCLS; c++) begin
            take[c] = grant_o && (req_cls_i == 2'(c));
        end
    end
endmodule

// File: rtl/txfc_credit_gate_chk.sv
module txfc_credit_gate_chk #(
    parameter int NC          = 3,
    parameter int HDR_W       = 8,
    parameter int RB_W        = 11,
    parameter int RXBUF_BYTES = 1024
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid_i,
    input logic [1:0]               req_cls_i,
    input logic                     grant_o,
    input logic [NC-1:0][HDR_W-1:0] lim_hdr_i,
    input logic [NC-1:0]            inf_hdr_i,
    input logic [NC-1:0][HDR_W-1:0] avail_hdr_o,
    input logic [RB_W-1:0]          np_out
);
    a_r8_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> req_valid_i);

    a_r5_no_grant_bad_class: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> (req_cls_i != 2'd3));

    a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        np_out <= RB_W'(RXBUF_BYTES));

    for (genvar c = 0; c < NC; c++) begin : g_chk
        a_r4_hdr_present: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_o && req_cls_i == 2'(c) && !inf_hdr_i[c]) |-> (avail_hdr_o[c] != '0));

        a_r1_hdr_step: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_o && req_cls_i == 2'(c)) |=>
            (!$stable(lim_hdr_i[c]) || avail_hdr_o[c] == HDR_W'($past(avail_hdr_o[c]) - 1'b1)));

        a_r5_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(grant_o && req_cls_i == 2'(c)) |=>
            (!$stable(lim_hdr_i[c]) || $stable(avail_hdr_o[c])));
    end
endmodule

bind txfc_credit_gate txfc_credit_gate_chk #(
    .NC(txfc_pkg::NCLS), .HDR_W(HDR_W), .RB_W(RB_W), .RXBUF_BYTES(RXBUF_BYTES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid_i(req_valid_i),
    .req_cls_i  (req_cls_i),
    .grant_o    (grant_o),
    .lim_hdr_i  (lim_hdr_i),
    .inf_hdr_i  (inf_hdr_i),
    .avail_hdr_o(avail_hdr_o),
    .np_out     (np_out_bytes)
);

// File: tb/txfc_credit_gate_tb_top.sv
module txfc_credit_gate_tb_top;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0][7:0]  lim_hdr_i = '0;
    logic [2:0][11:0] lim_data_i = '0;
    logic [2:0]       inf_hdr_i = '0;
    logic [2:0]       inf_data_i = '0;
    logic             req_valid_i = 1'b0;
    logic [1:0]       req_cls_i = '0;
    logic [12:0]      req_len_i = '0;
    logic [10:0]      req_rd_bytes_i = '0;
    logic             cpl_ret_valid_i = 1'b0;
    logic [10:0]      cpl_ret_bytes_i = '0;
    logic             grant_o;
    logic [2:0][7:0]  avail_hdr_o;
    logic [2:0][11:0] avail_data_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int used_h[3];
    int used_d[3];

    always #4 clk = ~clk;

    txfc_credit_gate dut_i (.*);

    task automatic chk(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_pools(input string tag);
        for (int c = 0; c < 3; c++) begin
            chk(int'(avail_hdr_o[c]), (int'(lim_hdr_i[c]) - used_h[c]) & 255, {tag, " hdr avail"});
            chk(int'(avail_data_o[c]), (int'(lim_data_i[c]) - used_d[c]) & 4095, {tag, " data avail"});
        end
    endtask

    function automatic int unit_cost(input int len);
        return (len + 15) / 16;
    endfunction

    // offer one packet for one cycle; model follows only when a grant is expected
    task automatic offer(input int cls, input int len, input int rd, input bit exp, input string tag);
        @(negedge clk);
        req_valid_i = 1'b1;
        req_cls_i = 2'(cls);
        req_len_i = 13'(len);
        req_rd_bytes_i = 11'(rd);
        #1 chk(int'(grant_o), int'(exp), {tag, " grant"});
        @(posedge clk);
        #1;
        req_valid_i = 1'b0;
        if (exp && cls < 3) begin
            used_h[cls] = (used_h[cls] + 1) & 255;
            used_d[cls] = (used_d[cls] + unit_cost(len)) & 4095;
        end
        check_pools(tag);
    endtask

    task automatic give_back(input int bytes);
        @(negedge clk);
        cpl_ret_valid_i = 1'b1;
        cpl_ret_bytes_i = 11'(bytes);
        @(posedge clk);
        #1 cpl_ret_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        lim_hdr_i[0] = 8'd10;  lim_data_i[0] = 12'd40;
        lim_hdr_i[1] = 8'd4;   lim_data_i[1] = 12'd0;
        lim_hdr_i[2] = 8'd6;   lim_data_i[2] = 12'd100;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #1 check_pools("R3 reset");
        chk(int'(grant_o), 0, "R8 idle grant");
    endtask

    task automatic t_posted();
        offer(0, 128, 0, 1'b1, "R1 R2 posted 128B");
        chk(int'(avail_data_o[0]), 32, "R2 128B costs 8");
        chk(int'(avail_hdr_o[0]), 9, "R1 one header used");
        chk(int'(avail_hdr_o[2]), 6, "R5 completion untouched");
    endtask

    task automatic t_cost();
        offer(0, 17, 0, 1'b1, "R2 17B");
        chk(int'(avail_data_o[0]), 30, "R2 17B costs 2");
        offer(0, 16, 0, 1'b1, "R2 16B");
        offer(0, 0, 0, 1'b1, "R2 0B");
        chk(int'(avail_data_o[0]), 29, "R2 empty payload costs 0");
        offer(0, 1, 0, 1'b1, "R2 1B");
    endtask

    task automatic t_wait();
        lim_data_i[0] = 12'(used_d[0] + 5);
        @(negedge clk);
        req_valid_i = 1'b1; req_cls_i = 2'd0; req_len_i = 13'd128;
        for (int i = 0; i < 3; i++) begin
            #1 chk(int'(grant_o), 0, "R4 short of data credits");
            @(negedge clk);
        end
        check_pools("R4 held request consumes nothing");
        lim_data_i[0] = 12'(used_d[0] + 8);
        #1 chk(int'(grant_o), 1, "R4 granted after limit rises");
        @(posedge clk);
        #1 req_valid_i = 1'b0;
        used_h[0] = used_h[0] + 1;
        used_d[0] = (used_d[0] + 8) & 4095;
        check_pools("R4 after release");
        chk(int'(avail_data_o[0]), 0, "R4 exact fit leaves zero");
    endtask

    task automatic t_hdr_inf();
        lim_hdr_i[0] = 8'(used_h[0]);
        lim_data_i[0] = 12'(used_d[0] + 100);
        offer(0, 0, 0, 1'b0, "R4 no header credit");
        inf_hdr_i[0] = 1'b1;
        offer(0, 0, 0, 1'b1, "R6 infinite header pool");
        inf_hdr_i[0] = 1'b0;
        lim_hdr_i[0] = 8'(used_h[0] + 5);
        lim_data_i[0] = 12'(used_d[0]);
        offer(0, 64, 0, 1'b0, "R4 no data credit");
        inf_data_i[0] = 1'b1;
        offer(0, 64, 0, 1'b1, "R6 infinite data pool");
        chk(int'(avail_data_o[0]), 4092, "R6 consumption still counted");
        inf_data_i[0] = 1'b0;
    endtask

    task automatic t_nonpost();
        lim_hdr_i[1] = 8'(used_h[1] + 20);
        offer(1, 0, 512, 1'b1, "R7 first read");
        offer(1, 0, 512, 1'b1, "R7 window exactly full");
        offer(1, 0, 1, 1'b0, "R7 one byte over window");
        give_back(600);
        offer(1, 0, 512, 1'b1, "R7 after partial return");
        offer(1, 0, 89, 1'b0, "R7 936+89 over window");
        offer(1, 0, 88, 1'b1, "R7 936+88 fits");
        give_back(2000);
        offer(1, 0, 1024, 1'b1, "R7 floor at zero");
        give_back(1024);
        offer(0, 0, 0, 1'b1, "R5 posted ignores read window");
    endtask

    task automatic t_badcls();
        offer(3, 0, 0, 1'b0, "R5 class code 3");
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 300; i++) begin
            lim_hdr_i[2] = 8'(used_h[2] + 1);
            if (i % 37 == 0) begin
                lim_data_i[2] = 12'(used_d[2] + 255);
                offer(2, 4096, 0, 1'b0, "R4 one credit short");
            end
            lim_data_i[2] = 12'(used_d[2] + 256);
            offer(2, 4096, 0, 1'b1, "R3 wrapping completion");
        end
        chk(used_h[2], 44, "R3 header count wrapped");
    endtask

    initial begin
        for (int c = 0; c < 3; c++) begin
            used_h[c] = 0;
            used_d[c] = 0;
        end
        t_reset();
        t_posted();
        t_cost();
        t_wait();
        t_hdr_inf();
        t_nonpost();
        t_badcls();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
        $finish;
    end
endmodule